// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a small up-counter (four bits by default) whose state moves only on the rising clock edge. Each edge applies one of four actions, in fixed priority. An active-low clear forces zero. Failing that, an active-low load copies a data word into the state. Failing that, the counter adds one if both of its active-high enables are asserted. Otherwise it holds its value.

A carry-out flag rises when the count sits at all ones and the trickle enable is high. It is combinational, so the next stage in a chain sees it in the same cycle. Wider counters are built by wiring each stage's carry-out to the trickle enable of the stage above. The clock, clear, load and parallel enable are shared across all stages.

The clear input is synchronous, so it can be fed from a decode of the count to shorten the modulus. Decoding the value N-1 makes the counter cycle through 0 to N-1.

Top module: `sync_bin_counter`

## Requirements
- R1: The count output changes only at a rising clock edge. Input changes between edges leave it unchanged.
- R2: When clear_n is low at a rising edge, the count becomes zero, whatever load_n, en_p and en_t are. This includes the case where load_n is low in the same cycle.
- R3: When clear_n is high and load_n is low at a rising edge, the count takes din, whatever en_p and en_t are.
- R4: When clear_n and load_n are both high and en_p and en_t are both high at a rising edge, the count increases by one.
- R5: When clear_n and load_n are both high and either en_p or en_t is low at a rising edge, the count holds its value.
- R6: Counting is plain binary. The all-ones value (15 at the default width) goes to 0 on the next count.
- R7: carry_out is 1 exactly when en_t is 1 and the count is all ones. en_p has no effect on it.
- R8: Two instances chained through carry_out into the upper stage's en_t count as one 8-bit counter. This includes the carry at the 255-to-0 wrap.
- R9: Driving clear_n from a decode of count value 9 makes the counter repeat 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear to zero, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load of din, active low |
| en_p | input | 1 | Count enable, active high, does not affect carry_out |
| en_t | input | 1 | Count enable, active high, also gates carry_out |
| din | input | WIDTH | Value copied into the count on a load |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | High while en_t is high and q is all ones |

## Verification
All state is held in the count register, and q exposes it directly. A wrong next-state choice therefore shows on q one edge after the edge that applied it. A wrong priority shows the same way, for example a load beating a clear.

A bad carry term appears on carry_out at once. In a chain it reaches the upper stage's count one edge later, so the 8-bit comparison exposes it at the 255-to-0 wrap. A wrong increment or wrap breaks the decoded-modulus sequence within ten cycles.

// File: rtl/cnt_pkg.sv
// Package cnt_pkg
// Shared types for the presettable counter. The action encoding is
// internal to the block; no port carries it.
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_mode_dec.sv
// Module cnt_mode_dec
// Picks the action the next rising edge applies. Priority: clear, then
// load, then count (both enables high), then hold.
// Assumes: all control inputs are active at the same clock edge.
module cnt_mode_dec
    import cnt_pkg::*;
(
    input  logic    clear_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);
    // Priority decode of the four control inputs.
    always_comb begin
        if (!clear_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_state_reg.sv
// Module cnt_state_reg
// Holds the count and applies the decoded action on each rising edge.
// Assumes: op is settled before the edge. There is no asynchronous
// path into the state.
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] nxt;

    // Select the next count from the decoded action.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = q + STEP;
            default:  nxt = q;
        endcase
    end

    // Update the count register on the rising edge.
    always_ff @(posedge clk) begin
        q <= nxt;
    end

    logic armed = 1'b0;
    // Enable the checks once the first edge has passed.
    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        (op == OP_CLEAR) |=> (q == '0));
    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!armed)
        (op == OP_LOAD) |=> (q == $past(din)));
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!armed)
        (op == OP_COUNT) |=> (q == $past(q) + STEP));
    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (!armed)
        (op == OP_HOLD) |=> $stable(q));
endmodule

// File: rtl/cnt_term_det.sv
// Module cnt_term_det
// Flags the all-ones count, gated only by the trickle enable, for
// same-cycle cascading into the next stage.
// Assumes: q comes straight from the state register.
module cnt_term_det #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // Combinational terminal-count flag.
    always_comb begin
        carry_out = en_t && (q == TOP);
    end
endmodule

// File: rtl/sync_bin_counter.sv
// Module sync_bin_counter
// Presettable synchronous up-counter with synchronous clear, parallel
// load, two count enables and a cascadable carry-out.
// Assumes: a single clock. clear_n can serve as the reset or be driven
// from a decode of q.
module sync_bin_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);
    cnt_op_e op;

    cnt_mode_dec u_dec (
        .clear_n (clear_n),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .op      (op)
    );

    cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .op  (op),
        .din (din),
        .q   (q)
    );

    cnt_term_det #(.WIDTH(WIDTH)) u_term (
        .q         (q),
        .en_t      (en_t),
        .carry_out (carry_out)
    );

    logic armed = 1'b0;
    // Enable the checks once the first edge has passed.
    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && en_p && carry_out) |=> (q == '0));
endmodule

// File: tb/sim_sync_bin_counter.sv
// Directed bench. u0 is the lower stage and u1 the upper stage of an
// 8-bit chain. u2 runs with its clear decoded from count value 9.
module sim_sync_bin_counter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       mr_n = 1'b1, pe_n = 1'b1, cep = 1'b0, cet = 1'b0;
    logic [3:0] d_lo = '0, d_hi = '0;
    logic [3:0] q_lo, q_hi;
    logic       tc_lo, tc_hi;

    logic       mr2_n = 1'b1;
    logic [3:0] q2;
    logic       tc2;
    logic       dec_clr_n;

    int checks = 0;
    int errors = 0;

    sync_bin_counter #(.WIDTH(4)) u0 (
        .clk(clk), .clear_n(mr_n), .load_n(pe_n), .en_p(cep), .en_t(cet),
        .din(d_lo), .q(q_lo), .carry_out(tc_lo));

    sync_bin_counter #(.WIDTH(4)) u1 (
        .clk(clk), .clear_n(mr_n), .load_n(pe_n), .en_p(cep), .en_t(tc_lo),
        .din(d_hi), .q(q_hi), .carry_out(tc_hi));

    assign dec_clr_n = mr2_n && (q2 != 4'd9);

    sync_bin_counter #(.WIDTH(4)) u2 (
        .clk(clk), .clear_n(dec_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(1'b1),
        .din(4'd0), .q(q2), .carry_out(tc2));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One rising edge, then a quarter period to settle before sampling.
    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic do_clear();
        mr_n = 0; pe_n = 1; cep = 1; cet = 1;
        tick();
        chk("R2 clear low", q_lo, 0);
        chk("R2 clear high", q_hi, 0);
        mr_n = 1; cep = 0; cet = 0;
    endtask

    task automatic do_conflict();
        mr_n = 0; pe_n = 0; d_lo = 4'd7; d_hi = 4'd5; cep = 1; cet = 1;
        tick();
        chk("R2 clear beats load", {q_hi, q_lo}, 0);
        mr_n = 1; pe_n = 1; cep = 0; cet = 0;
    endtask

    task automatic do_load_over_en();
        pe_n = 0; d_lo = 4'd10; d_hi = 4'd3; cep = 1; cet = 1;
        tick();
        chk("R3 load with enables high", {q_hi, q_lo}, 8'h3A);
        cep = 0; cet = 0; d_lo = 4'd6;
        tick();
        chk("R3 load with enables low", q_lo, 6);
        pe_n = 1;
    endtask

    task automatic do_between_edges();
        pe_n = 0; d_lo = 4'd1; cep = 1; cet = 1;
        #(CLK_PERIOD/4);
        chk("R1 no change before edge", q_lo, 6);
        d_lo = 4'd2;
        #1;
        chk("R1 stable mid-cycle", q_lo, 6);
        tick();
        chk("R1 loads at edge", q_lo, 2);
        pe_n = 1; cep = 0; cet = 0;
    endtask

    task automatic do_hold();
        cep = 0; cet = 1;
        tick();
        chk("R5 hold en_p low", q_lo, 2);
        cep = 1; cet = 0;
        tick();
        chk("R5 hold en_t low", q_lo, 2);
        cep = 0; cet = 0;
        tick();
        chk("R5 hold both low", q_lo, 2);
    endtask

    task automatic do_ref_sequence();
        int exp;
        mr_n = 0;
        tick();
        chk("R2 ref clear", q_lo, 0);
        mr_n = 1; pe_n = 0; d_lo = 4'd12;
        tick();
        chk("R3 ref preset", q_lo, 12);
        pe_n = 1; cep = 1; cet = 1;
        exp = 12;
        for (int i = 0; i < 6; i++) begin
            tick();
            exp = (exp + 1) % 16;
            chk("R4 R6 ref count", q_lo, exp);
        end
        cep = 0;
        tick();
        chk("R5 ref inhibit", q_lo, 2);
        cet = 0;
    endtask

    task automatic do_term();
        mr_n = 1; pe_n = 0; d_lo = 4'd15; d_hi = 4'd0; cep = 0; cet = 0;
        tick();
        pe_n = 1;
        #1;
        chk("R7 tc low when en_t low", tc_lo, 0);
        cet = 1;
        #1;
        chk("R7 tc ignores en_p low", tc_lo, 1);
        cep = 1;
        #1;
        chk("R7 tc with en_p high", tc_lo, 1);
        tick();
        chk("R6 wrap to zero", q_lo, 0);
        chk("R7 tc drops after wrap", tc_lo, 0);
        chk("R8 carry into upper", q_hi, 1);
        cep = 0; cet = 0;
    endtask

    task automatic do_chain();
        int model;
        pe_n = 0; d_lo = 4'hD; d_hi = 4'hF;
        tick();
        pe_n = 1; cep = 1; cet = 1;
        model = 8'hFD;
        chk("R8 chain load", {q_hi, q_lo}, model);
        for (int i = 0; i < 300; i++) begin
            if (model == 255) begin
                chk("R8 upper tc at 255", tc_hi, 1);
            end
            tick();
            model = (model + 1) % 256;
            if ((i % 8) == 0 || model < 3 || model > 252 || (model % 16) == 0)
                chk("R8 chain count", {q_hi, q_lo}, model);
        end
        cet = 0;
        tick();
        chk("R8 chain hold", {q_hi, q_lo}, model);
        cep = 0;
    endtask

    task automatic do_modulus();
        int model;
        mr2_n = 0;
        tick();
        mr2_n = 1;
        model = 0;
        chk("R9 mod start", q2, 0);
        for (int i = 0; i < 25; i++) begin
            tick();
            model = (model == 9) ? 0 : model + 1;
            chk("R9 mod ten", q2, model);
        end
    endtask

    initial begin
        #(CLK_PERIOD/4);
        do_clear();
        do_conflict();
        do_load_over_en();
        do_between_edges();
        do_hold();
        do_ref_sequence();
        do_term();
        do_chain();
        do_modulus();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule